// File: doc/BRIEF.md
# Gated Master/Slave Nibble Timer Pair

This block holds two 32-bit down-counting interval timers, one for each of two cooperating chips. Both are paced by one shared 8192 Hz tick enable. Each chip area has a control register whose lowest bit starts and stops that chip's timer. The second timer (the slave) is gated by the first (the master): it can only advance while both its own run bit and the master's run bit are set. Stopping the master therefore freezes both counts.

Software reaches the timers over a 4-bit register bus with single-cycle strobes. Each count appears as eight consecutive nibble addresses, least significant nibble first. A read of the lowest nibble takes a snapshot of the whole count, so the seven reads that follow form one coherent value even while the counter keeps moving. Nibble writes collect in a staging register. The counter takes the new value in one step when the top nibble is written.

Top module: `dual_nibble_timer`

## Requirements
- R1: After reset, both counts are 0, both run bits are 0, `master_running` and `slave_running` are 0, and every readable location returns 0.
- R2: On a clock edge with `tick_en`=1 and the master run bit set, the master count decreases by exactly one. With the run bit clear or `tick_en`=0, the count holds.
- R3: The slave count decreases by one per tick only when its own run bit and the master run bit are both 1. `slave_running` reports that AND, and `master_running` reports the master run bit.
- R4: A running counter at 0x00000000 becomes 0xFFFFFFFF on the next tick.
- R5: Address bit 10 selects the area (1 = master, 0 = slave). Offsets 0x3F8+k (k = 0..7) hold count bits [4k+3:4k].
- R6: Offset 0x30A in each area is that chip's control register. A write stores data bit 0 as the run bit, and a read returns {3'b000, run}.
- R7: A read at offset 0x3F8 returns the live low nibble and latches a snapshot of all 32 bits. Reads at 0x3F9..0x3FF return nibbles of the latest snapshot, not of the live count.
- R8: Writes at 0x3F8..0x3FE only fill the staging nibbles and leave the count unchanged. A write at 0x3FF loads {data, staged nibbles} into the count at that edge.
- R9: When a top-nibble write and a tick fall in the same cycle, the loaded value is kept and is not decremented. Counting resumes from it on the next tick.
- R10: Reads of any other offset return 0. Writes to any other offset change no count and no run bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle 8192 Hz advance strobe shared by both timers |
| bus_addr | input | 11 | Nibble address; bit 10 selects master area, bits 9:0 the offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 4 | Write nibble |
| bus_rdata | output | 4 | Read nibble, valid in the cycle of `bus_rd` |
| master_running | output | 1 | Master run bit |
| slave_running | output | 1 | Slave is actually advancing on ticks (own run AND master run) |

## Verification
Two pairs of functions can meet in one cycle. A top-nibble load can land on a tick, and a low-nibble snapshot read can be followed by a tick before the remaining nibbles are read. The bench drives `tick_en` high in the same cycle as the 0x3FF write and expects the exact loaded value, then one less after a single further tick. It also reads 0x3F8, lets a running timer tick, and then reads 0x3F9..0x3FF. It expects the nibbles of the pre-tick value, and a fresh full read then gives the post-tick value. Gating is swept over all four run-bit combinations, with both counters compared against an arithmetic model.

// File: rtl/tmr_pkg.sv
// Package: shared constants and types for the gated timer pair.
// Assumes a 10-bit offset space per chip area, with the count placed at the
// top of that space.
package tmr_pkg;
    localparam int OFS_W = 10;
    localparam logic [OFS_W-1:0] CTL_OFS = 10'h30A;

    typedef enum logic {
        CHIP_SLAVE  = 1'b0,
        CHIP_MASTER = 1'b1
    } chip_e;
endpackage

// File: rtl/timer_addr_dec.sv
// Module: timer_addr_dec
// Splits a bus address into area select, control-register hit, count-window
// hit and nibble index.
// Assumes NIB_N is a power of two, so that the count window sits aligned at
// the very top of the offset space.
module timer_addr_dec #(
    parameter int OFS_W = 10,
    parameter int NIB_N = 8,
    parameter int IDX_W = 3
) (
    input  logic [OFS_W:0]   addr,
    output logic             chip,
    output logic             hit_ctl,
    output logic             hit_cnt,
    output logic [IDX_W-1:0] nib_idx
);
    import tmr_pkg::*;

    localparam logic [OFS_W-1:0] CNT_BASE = OFS_W'((1 << OFS_W) - NIB_N);

    logic [OFS_W-1:0] offset;

    // Decode the offset into its target.
    always_comb begin
        offset  = addr[OFS_W-1:0];
        chip    = addr[OFS_W];
        hit_ctl = (offset == CTL_OFS);
        hit_cnt = (offset >= CNT_BASE);
        nib_idx = offset[IDX_W-1:0];
    end
endmodule

// File: rtl/timer_run_ctl.sv
// Module: timer_run_ctl
// Holds the run bit of one chip's timer-control register.
// Assumes the write strobe is already qualified by area and offset.
module timer_run_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    output logic run
);
    // Store bit 0 of a control write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run <= 1'b0;
        else if (wr_en)
            run <= wr_bit;
    end

    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(run)); // R6
endmodule

// File: rtl/nib_timer_core.sv
// Module: nib_timer_core
// A down counter with nibble-wide access. It has a staging register for
// loads and a snapshot register for coherent multi-nibble reads.
// Assumes the read and write strobes are already qualified to this timer's
// window, and that idx is the nibble index within it.
module nib_timer_core #(
    parameter int CNT_W = 32,
    parameter int NIB_N = CNT_W / 4,
    parameter int IDX_W = $clog2(NIB_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [3:0]       wr_nib,
    output logic [3:0]       rd_nib,
    output logic [CNT_W-1:0] count
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NIB_N - 1);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic [CNT_W-5:0] stage;
    logic [CNT_W-1:0] snap;
    logic             load;

    assign load = wr_en && (idx == TOP_IDX);

    // The counter: a load wins over a tick, otherwise decrement when advancing.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= {wr_nib, stage};
        else if (advance)
            count <= count - ONE;
    end

    // Collect the lower nibbles of a pending load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage <= '0;
        else if (wr_en && !load) begin
            for (int k = 0; k < NIB_N - 1; k++)
                if (idx == IDX_W'(k))
                    stage[k*4 +: 4] <= wr_nib;
        end
    end

    // Capture the whole count when the lowest nibble is read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            snap <= '0;
        else if (rd_en && idx == '0)
            snap <= count;
    end

    // Return the live low nibble, or a snapshot nibble for the others.
    always_comb begin
        if (idx == '0)
            rd_nib = count[3:0];
        else
            rd_nib = snap[idx*4 +: 4];
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !load) |=> $stable(count)); // R2
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && count != '0) |=> (count == $past(count) - ONE)); // R2
    AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && count == '0) |=> (count == '1)); // R4
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count[CNT_W-1 -: 4] == $past(wr_nib) && count[CNT_W-5:0] == $past(stage))); // R9
    AST_STAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !load && !advance) |=> $stable(count)); // R8
    AST_SNAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && idx == '0) |=> $stable(snap)); // R7
endmodule

// File: rtl/dual_nibble_timer.sv
// Module: dual_nibble_timer
// Top level: two nibble-accessible down counters with run bits, where the
// slave counter is gated by the master's run state.
// Assumes bus_rd and bus_wr are not asserted together, and that tick_en is
// a one-cycle strobe.
module dual_nibble_timer #(
    parameter int CNT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_en,
    input  logic [tmr_pkg::OFS_W:0] bus_addr,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    input  logic [3:0]            bus_wdata,
    output logic [3:0]            bus_rdata,
    output logic                  master_running,
    output logic                  slave_running
);
    import tmr_pkg::*;

    localparam int NIB_N = CNT_W / 4;
    localparam int IDX_W = $clog2(NIB_N);
    localparam int CHIPS = 2;
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NIB_N - 1);

    logic             sel_chip;
    logic             hit_ctl;
    logic             hit_cnt;
    logic [IDX_W-1:0] nib_idx;

    logic             run     [CHIPS];
    logic             adv     [CHIPS];
    logic             cnt_wr  [CHIPS];
    logic             cnt_rd  [CHIPS];
    logic             ctl_wr  [CHIPS];
    logic [3:0]       nib_out [CHIPS];
    logic [CNT_W-1:0] cnt_val [CHIPS];

    timer_addr_dec #(.OFS_W(OFS_W), .NIB_N(NIB_N), .IDX_W(IDX_W)) u_dec (
        .addr    (bus_addr),
        .chip    (sel_chip),
        .hit_ctl (hit_ctl),
        .hit_cnt (hit_cnt),
        .nib_idx (nib_idx)
    );

    for (genvar g = 0; g < CHIPS; g++) begin : g_chip
        // Qualify the bus strobes to this chip's area.
        always_comb begin
            cnt_wr[g] = bus_wr && hit_cnt && (sel_chip == 1'(g));
            cnt_rd[g] = bus_rd && hit_cnt && (sel_chip == 1'(g));
            ctl_wr[g] = bus_wr && hit_ctl && (sel_chip == 1'(g));
        end

        if (g == int'(CHIP_SLAVE)) begin : g_gated
            // The slave advances only while the master also runs.
            assign adv[g] = tick_en && run[g] && run[int'(CHIP_MASTER)];
        end else begin : g_free
            // The master advances on its own run bit.
            assign adv[g] = tick_en && run[g];
        end

        timer_run_ctl u_ctl (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (ctl_wr[g]),
            .wr_bit (bus_wdata[0]),
            .run    (run[g])
        );

        nib_timer_core #(.CNT_W(CNT_W), .NIB_N(NIB_N), .IDX_W(IDX_W)) u_core (
            .clk     (clk),
            .rst_n   (rst_n),
            .advance (adv[g]),
            .wr_en   (cnt_wr[g]),
            .rd_en   (cnt_rd[g]),
            .idx     (nib_idx),
            .wr_nib  (bus_wdata),
            .rd_nib  (nib_out[g]),
            .count   (cnt_val[g])
        );
    end

    // Steer the addressed location onto the read bus; 0 elsewhere.
    always_comb begin
        bus_rdata = 4'h0;
        if (bus_rd) begin
            if (hit_ctl)
                bus_rdata = {3'b000, run[sel_chip]};
            else if (hit_cnt)
                bus_rdata = nib_out[sel_chip];
        end
    end

    // Report the run states.
    assign master_running = run[int'(CHIP_MASTER)];
    assign slave_running  = run[int'(CHIP_SLAVE)] && run[int'(CHIP_MASTER)];

    AST_SLAVE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_running && !(cnt_wr[int'(CHIP_SLAVE)] && nib_idx == TOP_IDX))
        |=> $stable(cnt_val[int'(CHIP_SLAVE)])); // R3
    AST_CTL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit_ctl) |-> (bus_rdata[3:1] == 3'b000)); // R6
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !hit_ctl && !hit_cnt) |-> (bus_rdata == 4'h0)); // R10
    AST_GATE_IMPLIES: assert property (@(posedge clk) disable iff (!rst_n)
        slave_running |-> master_running); // R3
endmodule

// File: tb/tb_dual_nibble_timer.sv
// Bench for dual_nibble_timer: sweeps run-bit combinations, nibble
// positions and values, and the load/tick and snapshot/tick collisions
// against an arithmetic model.
module tb_dual_nibble_timer;
    localparam logic [9:0] CNT0 = 10'h3F8;
    localparam logic [9:0] CTL  = 10'h30A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [10:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_wdata = '0;
    logic [3:0]  bus_rdata;
    logic        master_running;
    logic        slave_running;

    int vectors = 0;
    int fails   = 0;
    logic [31:0] exp_c [2];
    bit          runb  [2];

    always #10 clk = ~clk;

    dual_nibble_timer dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_en        (tick_en),
        .bus_addr       (bus_addr),
        .bus_rd         (bus_rd),
        .bus_wr         (bus_wr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .master_running (master_running),
        .slave_running  (slave_running)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic bus_write(input bit m, input logic [9:0] ofs, input logic [3:0] d);
        bus_addr = {m, ofs}; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input bit m, input logic [9:0] ofs, output logic [3:0] d);
        bus_addr = {m, ofs}; bus_rd = 1'b1;
        #1 d = bus_rdata;
        step();
        bus_rd = 1'b0;
    endtask

    task automatic read_cnt(input bit m, output logic [31:0] v);
        logic [3:0] n;
        for (int i = 0; i < 8; i++) begin
            bus_read(m, CNT0 + 10'(i), n);
            v[i*4 +: 4] = n;
        end
    endtask

    task automatic write_cnt(input bit m, input logic [31:0] v);
        for (int i = 0; i < 8; i++)
            bus_write(m, CNT0 + 10'(i), v[i*4 +: 4]);
        exp_c[m] = v;
    endtask

    task automatic set_run(input bit m, input bit b);
        bus_write(m, CTL, {3'b101, b});
        runb[m] = b;
    endtask

    task automatic model_tick();
        if (runb[1]) exp_c[1] = exp_c[1] - 1;
        if (runb[0] && runb[1]) exp_c[0] = exp_c[0] - 1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            step();
            model_tick();
        end
        tick_en = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [3:0]  n;
        exp_c[0] = '0; exp_c[1] = '0; runb[0] = 0; runb[1] = 0;
        repeat (4) step();
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 master_running", 32'(master_running), 0);
        chk("R1 slave_running", 32'(slave_running), 0);
        for (int m = 0; m < 2; m++) begin
            read_cnt(m[0], v); chk("R1 count", v, 0);
            bus_read(m[0], CTL, n); chk("R1 ctl", 32'(n), 0);
        end

        // R8: lower-nibble writes stage only
        for (int i = 0; i < 7; i++) bus_write(1'b1, CNT0 + 10'(i), 4'(i + 8));
        read_cnt(1'b1, v); chk("R8 staged only", v, 0);
        bus_write(1'b1, 10'h3FF, 4'h1);
        exp_c[1] = 32'h1EDCBA98;
        read_cnt(1'b1, v); chk("R8 top load", v, exp_c[1]);
        read_cnt(1'b0, v); chk("R5 other area untouched", v, 0);

        // R5: every nibble position and value on both areas
        for (int m = 0; m < 2; m++)
            for (int i = 0; i < 8; i++)
                for (int d = 0; d < 16; d++) begin
                    v = 32'(d) << (4 * i);
                    write_cnt(m[0], v);
                    read_cnt(m[0], v); chk("R5 nibble position", v, exp_c[m]);
                end

        // R2/R3/R6: sweep all run-bit combinations with ticks
        write_cnt(1'b1, 32'h00001000);
        write_cnt(1'b0, 32'h00002000);
        for (int c = 0; c < 4; c++) begin
            set_run(1'b1, c[1]);
            set_run(1'b0, c[0]);
            bus_read(1'b1, CTL, n); chk("R6 master ctl readback", 32'(n), 32'(c[1]));
            bus_read(1'b0, CTL, n); chk("R6 slave ctl readback", 32'(n), 32'(c[0]));
            chk("R3 master_running", 32'(master_running), 32'(c[1]));
            chk("R3 slave_running", 32'(slave_running), 32'(c[0] & c[1]));
            ticks(3 + c);
            read_cnt(1'b1, v); chk("R2 master count", v, exp_c[1]);
            read_cnt(1'b0, v); chk("R3 slave count", v, exp_c[0]);
            step(); step();
            read_cnt(1'b1, v); chk("R2 hold without tick", v, exp_c[1]);
        end

        // R4: wrap from zero
        set_run(1'b1, 1); set_run(1'b0, 1);
        write_cnt(1'b0, 32'h0);
        write_cnt(1'b1, 32'h1);
        ticks(2);
        read_cnt(1'b0, v); chk("R4 slave wrap", v, 32'hFFFFFFFE);
        read_cnt(1'b1, v); chk("R4 master wrap", v, 32'hFFFFFFFF);

        // R7: snapshot survives a tick between nibble reads
        write_cnt(1'b1, 32'h50000000);
        bus_read(1'b1, CNT0, n); chk("R7 live low nibble", 32'(n), 0);
        v = exp_c[1];
        ticks(1);
        for (int i = 1; i < 8; i++) begin
            bus_read(1'b1, CNT0 + 10'(i), n);
            chk("R7 snapshot nibble", 32'(n), 32'(v[i*4 +: 4]));
        end
        read_cnt(1'b1, v); chk("R7 fresh read", v, 32'h4FFFFFFF);

        // R9: top-nibble load in the same cycle as a tick
        for (int i = 0; i < 7; i++) bus_write(1'b1, CNT0 + 10'(i), 4'h3);
        bus_addr = {1'b1, 10'h3FF}; bus_wdata = 4'h7; bus_wr = 1'b1; tick_en = 1'b1;
        step();
        bus_wr = 1'b0; tick_en = 1'b0;
        exp_c[0] = exp_c[0] - 1;
        exp_c[1] = 32'h73333333;
        read_cnt(1'b1, v); chk("R9 load wins", v, 32'h73333333);
        ticks(1);
        read_cnt(1'b1, v); chk("R9 resume count", v, 32'h73333332);
        read_cnt(1'b0, v); chk("R9 slave still ticked", v, exp_c[0]);

        // R3: stopping the master freezes the slave
        set_run(1'b1, 0);
        ticks(4);
        read_cnt(1'b0, v); chk("R3 slave frozen", v, exp_c[0]);
        chk("R3 slave_running low", 32'(slave_running), 0);

        // R10: unmapped offsets
        bus_read(1'b1, 10'h000, n); chk("R10 read 0x000", 32'(n), 0);
        bus_read(1'b0, 10'h30B, n); chk("R10 read 0x30B", 32'(n), 0);
        bus_read(1'b1, 10'h3F7, n); chk("R10 read 0x3F7", 32'(n), 0);
        bus_write(1'b1, 10'h3F7, 4'hF);
        bus_write(1'b1, 10'h30B, 4'hF);
        bus_write(1'b0, 10'h309, 4'hF);
        bus_read(1'b1, CTL, n); chk("R10 master run kept", 32'(n), 0);
        bus_read(1'b0, CTL, n); chk("R10 slave run kept", 32'(n), 1);
        read_cnt(1'b1, v); chk("R10 master count kept", v, exp_c[1]);
        read_cnt(1'b0, v); chk("R10 slave count kept", v, exp_c[0]);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule